// File: doc/BRIEF.md
# Static Branch Predictor with Return Stack

This block gives a next-PC guess for every branch the decoder presents, using no history. Direction follows fixed rules: the branch class decides, and for conditional branches the sign of the displacement decides. Unconditional direct branches and calls go to their decoded target. Indirect jumps fall through. Conditional branches go to their target only when the target lies below their own PC.

Return targets come from a sixteen-entry circular return-address stack. A call pushes its fall-through address and a return pops the most recent one. A push into a full stack overwrites the oldest entry, so deep call chains lose their outermost return addresses without any fault. A return that finds the stack empty falls back to its own fall-through address and raises a low-confidence flag.

The prediction is combinational from the inputs. Stack changes take effect on the next rising clock edge. The packed stack state is visible on an output, so the commit side can keep a copy and write it back on a misprediction with a one-cycle flush.

Top module: `sbp_static_pred`

## Requirements
- R1: After synchronous active-high reset the stack is empty, so `ras_state` reads 0 and a return predicts with `pred_lowconf` high.
- R2: A valid branch of class 0 (unconditional direct) predicts taken with `pred_next_pc` equal to `br_target`.
- R3: A valid branch of class 2 (indirect jump) predicts not taken with `pred_next_pc` equal to `br_fallthru`.
- R4: A valid branch of class 1 (conditional) predicts taken to `br_target` when `br_target` is below `br_pc` as unsigned values. When the target is equal to or above `br_pc`, it predicts not taken to `br_fallthru`.
- R5: A valid branch of class 3 (call) predicts taken to `br_target` and pushes `br_fallthru` at the next rising edge.
- R6: A valid branch of class 4 (return) with a non-empty stack predicts taken to the most recently pushed address that has not yet been popped. It pops that entry at the next edge, in last-in, first-out order.
- R7: A push into a stack that already holds 16 entries overwrites the oldest entry and leaves the count at 16. After 17 calls, 16 returns yield the 16 newest addresses, and the 17th return finds the stack empty.
- R8: A return on an empty stack predicts taken to `br_fallthru`, drives `pred_lowconf` high and leaves the stack state unchanged. `pred_lowconf` is low in every other case.
- R9: When `flush_valid` is high, the stack state becomes `flush_state` at the next edge. This holds even if a call or return is also presented in that cycle.
- R10: When `br_valid` is low, or the class code is 5, 6 or 7, the output is not taken to `br_fallthru` and the stack state does not change.
- R11: `ras_state` packs the entry count in bits [8:4] and the top-of-stack write pointer in bits [3:0]. The pointer is the slot the next push writes, and it advances by one, modulo 16, per push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A decoded branch is presented |
| br_class | input | 3 | Branch class: 0 unconditional, 1 conditional, 2 indirect, 3 call, 4 return |
| br_pc | input | 32 | Address of the branch |
| br_target | input | 32 | Decoded target address |
| br_fallthru | input | 32 | Address of the next sequential instruction |
| flush_valid | input | 1 | Restore the stack state from `flush_state` |
| flush_state | input | 9 | Saved stack state (count and pointer) |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_lowconf | output | 1 | Return predicted from an empty stack |
| ras_state | output | 9 | Current packed stack state for checkpointing |

## Verification
A flush and a stack-changing call or return can arrive in the same cycle; the restore must win and the branch's push or pop must vanish. The bench provokes this with a directed call presented together with a flush to a state captured earlier. Random traffic also raises flush on about one cycle in sixteen while calls and returns keep flowing. Each case is judged by comparing the next cycle's `ras_state`, and the later popped addresses, against a bench model. In that model the restore sets only the count and pointer and leaves the stored addresses as they are.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [2:0] {
    BR_UNCOND = 3'd0,
    BR_COND   = 3'd1,
    BR_INDIR  = 3'd2,
    BR_CALL   = 3'd3,
    BR_RET    = 3'd4
  } br_class_e;

  function automatic logic is_known_class(input logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/sbp_dir_rules.sv
module sbp_dir_rules
  import sbp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic [2:0]    cls,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] fallthru,
  input  logic [AW-1:0] stack_top,
  input  logic          stack_empty,
  output logic          taken,
  output logic [AW-1:0] next_pc,
  output logic          lowconf,
  output logic          do_push,
  output logic          do_pop
);
  logic backward;
  assign backward = target < pc;

  always_comb begin
    taken   = 1'b0;
    next_pc = fallthru;
    lowconf = 1'b0;
    do_push = 1'b0;
    do_pop  = 1'b0;
    if (valid && is_known_class(cls)) begin
      case (br_class_e'(cls))
        BR_UNCOND: begin
          taken   = 1'b1;
          next_pc = target;
        end
        BR_COND: begin
          taken   = backward;
          next_pc = backward ? target : fallthru;
        end
        BR_CALL: begin
          taken   = 1'b1;
          next_pc = target;
          do_push = 1'b1;
        end
        BR_RET: begin
          taken = 1'b1;
          if (stack_empty) begin
            lowconf = 1'b1;
          end else begin
            next_pc = stack_top;
            do_pop  = 1'b1;
          end
        end
        default: begin
          taken   = 1'b0;
          next_pc = fallthru;
        end
      endcase
    end
  end
endmodule

// File: rtl/sbp_ras_ctrl.sv
module sbp_ras_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int STW  = CNTW + PTRW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  input  logic [STW-1:0]  flush_state,
  output logic [STW-1:0]  state,
  output logic            empty,
  output logic            wr_en,
  output logic [PTRW-1:0] wr_idx,
  output logic [PTRW-1:0] rd_idx
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [PTRW-1:0] LAST_IDX = PTRW'(DEPTH - 1);

  logic [PTRW-1:0] ptr_q;
  logic [CNTW-1:0] cnt_q;
  logic [PTRW-1:0] ptr_inc;
  logic [PTRW-1:0] ptr_dec;

  assign ptr_inc = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? LAST_IDX : ptr_q - 1'b1;

  assign empty  = (cnt_q == '0);
  assign wr_en  = push && !flush;
  assign wr_idx = ptr_q;
  assign rd_idx = ptr_dec;
  assign state  = {cnt_q, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      cnt_q <= flush_state[STW-1:PTRW];
      ptr_q <= flush_state[PTRW-1:0];
    end else if (push) begin
      ptr_q <= ptr_inc;
      if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      ptr_q <= ptr_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sbp_ras_mem.sv
module sbp_ras_mem #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PTRW-1:0] waddr,
  input  logic [AW-1:0]   wdata,
  input  logic [PTRW-1:0] raddr,
  output logic [AW-1:0]   rdata
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbp_static_pred.sv
module sbp_static_pred #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int STW  = CNTW + PTRW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           br_valid,
  input  logic [2:0]     br_class,
  input  logic [AW-1:0]  br_pc,
  input  logic [AW-1:0]  br_target,
  input  logic [AW-1:0]  br_fallthru,
  input  logic           flush_valid,
  input  logic [STW-1:0] flush_state,
  output logic           pred_taken,
  output logic [AW-1:0]  pred_next_pc,
  output logic           pred_lowconf,
  output logic [STW-1:0] ras_state
);
  logic            push;
  logic            pop;
  logic            empty;
  logic            wr_en;
  logic [PTRW-1:0] wr_idx;
  logic [PTRW-1:0] rd_idx;
  logic [AW-1:0]   top_addr;

  sbp_dir_rules #(.AW(AW)) u_rules (
    .valid       (br_valid),
    .cls         (br_class),
    .pc          (br_pc),
    .target      (br_target),
    .fallthru    (br_fallthru),
    .stack_top   (top_addr),
    .stack_empty (empty),
    .taken       (pred_taken),
    .next_pc     (pred_next_pc),
    .lowconf     (pred_lowconf),
    .do_push     (push),
    .do_pop      (pop)
  );

  sbp_ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .pop         (pop),
    .flush       (flush_valid),
    .flush_state (flush_state),
    .state       (ras_state),
    .empty       (empty),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .rd_idx      (rd_idx)
  );

  sbp_ras_mem #(.AW(AW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (br_fallthru),
    .raddr (rd_idx),
    .rdata (top_addr)
  );
endmodule

// File: rtl/sbp_static_pred_chk.sv
module sbp_static_pred_chk #(
  parameter int AW  = 32,
  parameter int STW = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           br_valid,
  input logic [2:0]     br_class,
  input logic [AW-1:0]  br_pc,
  input logic [AW-1:0]  br_target,
  input logic [AW-1:0]  br_fallthru,
  input logic           flush_valid,
  input logic [STW-1:0] flush_state,
  input logic           pred_taken,
  input logic [AW-1:0]  pred_next_pc,
  input logic           pred_lowconf,
  input logic [STW-1:0] ras_state
);
  a_r2_uncond_taken: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_class == 3'd0) |-> (pred_taken && pred_next_pc == br_target));

  a_r3_indirect_falls: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_class == 3'd2) |-> (!pred_taken && pred_next_pc == br_fallthru));

  a_r4_cond_sign: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_class == 3'd1) |-> (pred_taken == (br_target < br_pc)));

  a_r5_call_target: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_class == 3'd3) |-> (pred_taken && pred_next_pc == br_target));

  a_r8_lowconf_only_ret: assert property (@(posedge clk) disable iff (rst)
    pred_lowconf |-> (br_valid && br_class == 3'd4 && pred_next_pc == br_fallthru));

  a_r9_flush_restore: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> (ras_state == $past(flush_state)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!flush_valid && !(br_valid && (br_class == 3'd3 || br_class == 3'd4))) |=> $stable(ras_state));

  a_r10_idle_nt: assert property (@(posedge clk) disable iff (rst)
    (!br_valid || br_class > 3'd4) |-> (!pred_taken && pred_next_pc == br_fallthru));
endmodule

bind sbp_static_pred sbp_static_pred_chk #(.AW(AW), .STW(STW)) u_chk (.*);

// File: tb/test_sbp_static_pred.sv
`timescale 1ns/1ps
module test_sbp_static_pred;
  localparam int AW = 32;
  localparam int STW = 9;

  logic           clk = 1'b0;
  logic           rst;
  logic           br_valid;
  logic [2:0]     br_class;
  logic [AW-1:0]  br_pc, br_target, br_fallthru;
  logic           flush_valid;
  logic [STW-1:0] flush_state;
  logic           pred_taken;
  logic [AW-1:0]  pred_next_pc;
  logic           pred_lowconf;
  logic [STW-1:0] ras_state;

  always #2 clk = ~clk;

  sbp_static_pred i_sbp_static_pred (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_mem [16];
  int m_cnt = 0;
  int m_ptr = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [STW-1:0] m_state();
    return {m_cnt[4:0], m_ptr[3:0]};
  endfunction

  function automatic string cls_tag(input bit v, input logic [2:0] c);
    if (!v || c > 3'd4) return "R10";
    case (c)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] c, input logic [AW-1:0] pc,
                      input logic [AW-1:0] tg, input logic [AW-1:0] ft,
                      input bit fl, input logic [STW-1:0] fs, input string xtag);
    bit e_t, e_l;
    logic [AW-1:0] e_n;
    string tag;
    @(negedge clk);
    br_valid = v; br_class = c; br_pc = pc; br_target = tg; br_fallthru = ft;
    flush_valid = fl; flush_state = fs;
    #1;
    e_t = 1'b0; e_n = ft; e_l = 1'b0;
    if (v) begin
      case (c)
        3'd0: begin e_t = 1'b1; e_n = tg; end
        3'd1: begin e_t = (tg < pc); e_n = (tg < pc) ? tg : ft; end
        3'd3: begin e_t = 1'b1; e_n = tg; end
        3'd4: begin
          e_t = 1'b1;
          if (m_cnt > 0) e_n = m_mem[(m_ptr + 15) % 16];
          else e_l = 1'b1;
        end
        default: ;
      endcase
    end
    tag = (xtag != "") ? xtag : cls_tag(v, c);
    if (v && c == 3'd4 && m_cnt == 0) tag = "R8";
    check(pred_taken == e_t, {tag, " taken"}, 64'(pred_taken), 64'(e_t));
    check(pred_next_pc == e_n, {tag, " next_pc"}, 64'(pred_next_pc), 64'(e_n));
    check(pred_lowconf == e_l, {tag, " lowconf"}, 64'(pred_lowconf), 64'(e_l));
    check(ras_state == m_state(), "R11 ras_state", 64'(ras_state), 64'(m_state()));
    if (fl) begin
      m_cnt = int'(fs[8:4]);
      m_ptr = int'(fs[3:0]);
    end else if (v && c == 3'd3) begin
      m_mem[m_ptr] = ft;
      m_ptr = (m_ptr + 1) % 16;
      if (m_cnt < 16) m_cnt++;
    end else if (v && c == 3'd4 && m_cnt > 0) begin
      m_ptr = (m_ptr + 15) % 16;
      m_cnt--;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [STW-1:0] saved;
    void'($urandom(32'd4242));
    rst = 1'b1; br_valid = 0; br_class = 0; br_pc = 0; br_target = 0;
    br_fallthru = 0; flush_valid = 0; flush_state = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(ras_state == '0, "R1 reset state", 64'(ras_state), 64'd0);
    step(1, 3'd4, 32'h100, 32'h0, 32'h104, 0, '0, "R1");
    step(1, 3'd0, 32'h200, 32'h80, 32'h204, 0, '0, "R2");
    step(1, 3'd2, 32'h300, 32'h10, 32'h304, 0, '0, "R3");
    step(1, 3'd1, 32'h400, 32'h3f0, 32'h404, 0, '0, "R4");
    step(1, 3'd1, 32'h400, 32'h400, 32'h404, 0, '0, "R4");
    step(1, 3'd1, 32'h400, 32'h500, 32'h404, 0, '0, "R4");
    step(0, 3'd3, 32'h500, 32'h900, 32'h504, 0, '0, "R10");
    step(1, 3'd6, 32'h500, 32'h100, 32'h504, 0, '0, "R10");
    for (int i = 0; i < 17; i++)
      step(1, 3'd3, 32'h1000 + 32'(i) * 16, 32'h8000, 32'h1004 + 32'(i) * 16, 0, '0, "R7");
    for (int i = 0; i < 17; i++)
      step(1, 3'd4, 32'h9000, 32'h0, 32'h9004, 0, '0, "R7");
    step(1, 3'd3, 32'h2000, 32'h6000, 32'h2004, 0, '0, "R5");
    saved = m_state();
    step(1, 3'd3, 32'h2100, 32'h6000, 32'h2104, 0, '0, "R5");
    step(1, 3'd3, 32'h2200, 32'h6000, 32'h2204, 1, saved, "R9");
    step(1, 3'd4, 32'h7000, 32'h0, 32'h7004, 0, '0, "R9");
    step(1, 3'd4, 32'h7000, 32'h0, 32'h7004, 1, saved, "R9");
    step(1, 3'd4, 32'h7000, 32'h0, 32'h7004, 0, '0, "R6");
    saved = m_state();
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pc;
      bit fl;
      pc = $urandom() & 32'hffff_fffc;
      fl = ($urandom_range(0, 15) == 0);
      step($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)), pc,
           $urandom() & 32'hffff_fffc, pc + 32'd4, fl, saved, "");
      if (!fl && $urandom_range(0, 7) == 0) saved = m_state();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule